// File: doc/BRIEF.md
# Priority-Arbitrated HDLC Channel Multiplexer

This block picks which source drives an outgoing serial data line. The first source is an upstream serial input. The second is a local HDLC transmitter, which arrives as a ready/valid bit stream that already carries its flags and stuffed zeros. While the local transmitter owns the line, an active-low busy output tells the upstream side that its data is not being taken. A receive line is also passed straight through to a second output.

Every decision advances on a bit-enable strobe that marks the valid bit positions of the selected channel. Cycles without the strobe change nothing, so a channel two bits wide per frame works the same way as a full-rate stream. A transmit request is a one-cycle pulse, latched together with a force flag:
- With the force flag clear, the request waits until the upstream line has been idle for eight consecutive ones.
- With the force flag set, the upstream frame is cut off at once and seven ones are sent before the local frame.

After the local closing flag, the line holds ones for eight bit-times before it is handed back. A request that arrives during that window takes the line again straight after the window ends, and busy never rises in between.

Top module: `hdlc_chan_mux`

## Requirements
- R1: While the block does not own the line (busyN high), lineOut equals upIn in every cycle.
- R2: With a request pending and the force flag clear, the local frame starts on the bit-enable cycle that follows the eighth consecutive upstream one. Until then busyN stays high and srcReady stays low.
- R3: When the local frame starts, busyN goes low, and it stays low for the whole local frame.
- R4: With a request pending and the force flag set, the upstream bit on the next bit-enable cycle is still forwarded. After it, lineOut carries exactly seven ones, on seven bit-enable cycles, and then the local frame starts.
- R5: The bit consumed with srcEnd high is the final 0 of the closing flag. After it, lineOut is 1 for eight bit-enable cycles with busyN low. busyN then returns high if no request is pending.
- R6: A request that arrives before the eight-bit release window ends keeps busyN low. The next frame starts on the bit-enable cycle right after the eighth one.
- R7: rxOut equals rxIn in every cycle, whatever the multiplexer state.
- R8: Cycles with bitEn low change neither the state, the upstream idle count nor the window count.
- R9: The upstream idle count is cleared by every 0 seen on a bit-enable cycle and saturates at eight.
- R10: srcReady is high only while the local transmitter owns the line. A source bit is consumed only on a cycle with bitEn, srcValid and srcReady all high.
- R11: While the block owns the line but has no local bit to send (the abort fill, the release window, or srcValid low during the frame), lineOut is 1.
- R12: After reset no request is pending, busyN is high, srcReady is low, the idle count is zero and lineOut follows upIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Marks a valid bit position of the selected channel |
| upIn | input | 1 | Upstream serial data |
| rxIn | input | 1 | Receive serial data |
| txReq | input | 1 | One-cycle transmit request pulse |
| forceAbort | input | 1 | Force flag, latched with txReq |
| srcBit | input | 1 | Local HDLC bit |
| srcValid | input | 1 | srcBit is valid |
| srcEnd | input | 1 | srcBit is the final bit of the closing flag |
| lineOut | output | 1 | Outgoing serial data |
| busyN | output | 1 | Low while upstream data is not accepted |
| rxOut | output | 1 | Pass-through of rxIn |
| srcReady | output | 1 | Block accepts a local bit |

## Verification
The assertions assume that txReq is a single-cycle pulse. They also assume that srcBit, srcValid and srcEnd change only between consumed bits, and that srcEnd marks only the last bit of a frame. The bench meets these conditions because it serves the source from a queue. It pops the queue only on the cycle where the reference model consumes a bit, and it raises srcEnd only on the last 0 of each closing flag. Requests are issued as isolated pulses, including one placed inside the release window and one under a sparse bit-enable pattern of two enabled cycles in eight.

// File: rtl/hdlc_mux_pkg.sv
package hdlc_mux_pkg;
  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_SEND  = 2'd1,
    ST_ABORT = 2'd2,
    ST_REL   = 2'd3
  } muxState_e;

  typedef struct packed {
    logic selSrc;
    logic selOnes;
    logic clrWin;
  } muxStrobe_t;
endpackage

// File: rtl/hdlc_mux_dp.sv
module hdlc_mux_dp
  import hdlc_mux_pkg::*;
#(
  parameter int IDLE_RUN = 8,
  parameter int WIN_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             upIn,
  input  logic             srcBit,
  input  logic             srcValid,
  input  muxStrobe_t       stb,
  output logic             lineOut,
  output logic             idleFull,
  output logic [WIN_W-1:0] winCnt
);
  localparam int IDLE_W = $clog2(IDLE_RUN + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_RUN);

  logic [IDLE_W-1:0] idleCnt;
  logic [IDLE_W-1:0] idleNext;

  // run of upstream ones; cleared by a zero, saturating
  always_comb begin
    if (!upIn)                 idleNext = '0;
    else if (idleCnt == IDLE_MAX) idleNext = IDLE_MAX;
    else                       idleNext = idleCnt + 1'b1;
  end

  assign idleFull = (idleNext == IDLE_MAX);

  always_ff @(posedge clk) begin
    if (!rstN)      idleCnt <= '0;
    else if (bitEn) idleCnt <= idleNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           winCnt <= '0;
    else if (bitEn) begin
      if (stb.clrWin)    winCnt <= '0;
      else               winCnt <= winCnt + 1'b1;
    end
  end

  always_comb begin
    if (stb.selSrc)       lineOut = srcValid ? srcBit : 1'b1;
    else if (stb.selOnes) lineOut = 1'b1;
    else                  lineOut = upIn;
  end

  a_r9_idle_saturates: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_MAX);
  a_r8_idle_held: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(idleCnt));
endmodule

// File: rtl/hdlc_mux_ctl.sv
module hdlc_mux_ctl
  import hdlc_mux_pkg::*;
#(
  parameter int ABORT_FILL  = 7,
  parameter int RELEASE_RUN = 8,
  parameter int WIN_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             txReq,
  input  logic             forceAbort,
  input  logic             srcValid,
  input  logic             srcEnd,
  input  logic             idleFull,
  input  logic [WIN_W-1:0] winCnt,
  output muxStrobe_t       stb,
  output logic             busyN,
  output logic             srcReady
);
  localparam logic [WIN_W-1:0] FILL_LAST = WIN_W'(ABORT_FILL - 1);
  localparam logic [WIN_W-1:0] REL_LAST  = WIN_W'(RELEASE_RUN - 1);

  muxState_e state, stateNext;
  logic pendQ, frcQ;
  logic startSend, take;

  assign srcReady = (state == ST_SEND);
  assign busyN    = (state == ST_PASS);
  assign take     = bitEn && srcReady && srcValid;

  always_comb begin
    stateNext  = state;
    startSend  = 1'b0;
    stb.clrWin = 1'b0;
    unique case (state)
      ST_PASS: if (bitEn && pendQ) begin
        if (frcQ) begin
          stateNext  = ST_ABORT;
          stb.clrWin = 1'b1;
        end else if (idleFull) begin
          stateNext = ST_SEND;
          startSend = 1'b1;
        end
      end
      ST_SEND: if (take && srcEnd) begin
        stateNext  = ST_REL;
        stb.clrWin = 1'b1;
      end
      ST_ABORT: if (bitEn && winCnt == FILL_LAST) begin
        stateNext = ST_SEND;
        startSend = 1'b1;
      end
      ST_REL: if (bitEn && winCnt == REL_LAST) begin
        if (pendQ) begin
          stateNext = ST_SEND;
          startSend = 1'b1;
        end else begin
          stateNext = ST_PASS;
        end
      end
      default: stateNext = ST_PASS;
    endcase
  end

  assign stb.selSrc  = (state == ST_SEND);
  assign stb.selOnes = (state == ST_ABORT) || (state == ST_REL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_PASS;
      pendQ <= 1'b0;
      frcQ  <= 1'b0;
    end else begin
      state <= stateNext;
      pendQ <= (pendQ && !startSend) || txReq;
      if (txReq) frcQ <= forceAbort;
    end
  end

  a_r2_wait_for_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busyN && bitEn && pendQ && !frcQ && !idleFull) |=> busyN);
  a_r4_abort_fill: assert property (@(posedge clk) disable iff (!rstN)
    (busyN && bitEn && pendQ && frcQ) |=> (!busyN && !srcReady));
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REL && bitEn && winCnt == REL_LAST && pendQ) |=> (srcReady && !busyN));
  a_r8_hold_without_en: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn && !txReq) |=> ($stable(busyN) && $stable(srcReady)));
endmodule

// File: rtl/hdlc_chan_mux.sv
module hdlc_chan_mux
  import hdlc_mux_pkg::*;
#(
  parameter int IDLE_RUN    = 8,
  parameter int ABORT_FILL  = 7,
  parameter int RELEASE_RUN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic upIn,
  input  logic rxIn,
  input  logic txReq,
  input  logic forceAbort,
  input  logic srcBit,
  input  logic srcValid,
  input  logic srcEnd,
  output logic lineOut,
  output logic busyN,
  output logic rxOut,
  output logic srcReady
);
  localparam int WIN_MAX = (ABORT_FILL > RELEASE_RUN) ? ABORT_FILL : RELEASE_RUN;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);

  muxStrobe_t stb;
  logic idleFull;
  logic [WIN_W-1:0] winCnt;

  assign rxOut = rxIn;

  hdlc_mux_ctl #(
    .ABORT_FILL(ABORT_FILL), .RELEASE_RUN(RELEASE_RUN), .WIN_W(WIN_W)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .txReq(txReq),
    .forceAbort(forceAbort), .srcValid(srcValid), .srcEnd(srcEnd),
    .idleFull(idleFull), .winCnt(winCnt), .stb(stb),
    .busyN(busyN), .srcReady(srcReady)
  );

  hdlc_mux_dp #(
    .IDLE_RUN(IDLE_RUN), .WIN_W(WIN_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .upIn(upIn),
    .srcBit(srcBit), .srcValid(srcValid), .stb(stb),
    .lineOut(lineOut), .idleFull(idleFull), .winCnt(winCnt)
  );

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    busyN |-> (lineOut == upIn));
  a_r11_ones_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && (!srcReady || !srcValid)) |-> lineOut);
  a_r10_ready_owns: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> !busyN);
endmodule

// File: tb/test_hdlc_chan_mux.sv
module test_hdlc_chan_mux;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, upIn = 1'b1, rxIn = 1'b0, txReq = 1'b0, forceAbort = 1'b0;
  logic srcBit = 1'b0, srcValid = 1'b0, srcEnd = 1'b0;
  logic lineOut, busyN, rxOut, srcReady;

  always #10 clk = ~clk;

  hdlc_chan_mux i_hdlc_chan_mux (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .upIn(upIn), .rxIn(rxIn),
    .txReq(txReq), .forceAbort(forceAbort), .srcBit(srcBit),
    .srcValid(srcValid), .srcEnd(srcEnd), .lineOut(lineOut),
    .busyN(busyN), .rxOut(rxOut), .srcReady(srcReady)
  );

  int errors = 0, checks = 0;
  bit qBit[$];
  bit qEnd[$];
  // reference model: 0 upstream, 1 local frame, 2 abort fill, 3 release
  int mSt = 0, mIdle = 0, mWin = 0;
  bit mPend = 0, mFrc = 0;
  int busyRises = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tagOf();
    if (!rstN) return "R12";
    case (mSt)
      0: return mPend ? (mFrc ? "R4" : "R2") : "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic loadFrame(int nData);
    for (int i = 0; i < nData; i++) begin qBit.push_back(($urandom & 1) != 0); qEnd.push_back(0); end
    for (int i = 0; i < 8; i++) begin
      qBit.push_back(i != 0 && i != 7);
      qEnd.push_back(i == 7);
    end
  endtask

  task automatic step(bit u, bit en, bit req, bit frc);
    bit expLine, expBusy, expRdy, take, start, busyWas;
    int upNew, nxt;
    @(negedge clk);
    upIn = u; bitEn = en; txReq = req; forceAbort = frc;
    rxIn = ($urandom & 1) != 0;
    srcValid = qBit.size() > 0;
    srcBit = srcValid ? qBit[0] : 1'b0;
    srcEnd = srcValid ? qEnd[0] : 1'b0;
    #5;
    expBusy = (mSt == 0);
    expRdy = (mSt == 1);
    if (mSt == 0) expLine = u;
    else if (mSt == 1) expLine = srcValid ? srcBit : 1'b1;
    else expLine = 1'b1;
    chk(lineOut === expLine, (mSt != 0 && mSt != 1) ? "R11" : tagOf(), "lineOut", lineOut, expLine);
    chk(busyN === expBusy, tagOf(), "busyN", busyN, expBusy);
    chk(srcReady === expRdy, "R10", "srcReady", srcReady, expRdy);
    chk(rxOut === rxIn, "R7", "rxOut", rxOut, rxIn);
    busyWas = busyN;
    @(posedge clk);
    if (!rstN) begin
      mSt = 0; mIdle = 0; mWin = 0; mPend = 0; mFrc = 0;
    end else begin
      upNew = u ? ((mIdle >= 8) ? 8 : mIdle + 1) : 0;   // R9
      take = en && mSt == 1 && srcValid;
      start = 0; nxt = mSt;
      if (en) begin
        case (mSt)
          0: if (mPend) begin
               if (mFrc) begin nxt = 2; mWin = 0; end
               else if (upNew == 8) begin nxt = 1; start = 1; end
             end
          1: if (take && qEnd[0]) begin nxt = 3; mWin = 0; end
          2: if (mWin == 6) begin nxt = 1; start = 1; end else mWin++;
          default: if (mWin == 7) begin
               if (mPend) begin nxt = 1; start = 1; end else nxt = 0;
             end else mWin++;
        endcase
        mIdle = upNew;   // R8: only on bit-enable cycles
      end
      if (take) begin void'(qBit.pop_front()); void'(qEnd.pop_front()); end
      mSt = nxt;
      mPend = (mPend && !start) || req;
      if (req) mFrc = frc;
    end
    #1;
    if (!busyWas && busyN) busyRises++;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    // R12: reset state with varied upstream
    for (int i = 0; i < 4; i++) step(i[0], 1, 0, 0);
    rstN = 1'b1;
    // R1: plain pass-through
    for (int i = 0; i < 30; i++) step(($urandom & 1) != 0, 1, 0, 0);
    // R2/R9: wait path, upstream zeros break the run of ones
    loadFrame(6);
    step(0, 1, 1, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    chk(busyN === 1'b1, "R2", "busyN before 8 ones", busyN, 1);
    for (int i = 0; i < 40; i++) begin
      step(1, 1, 0, 0);
      if (srcReady) begin chk(busyN === 1'b0, "R3", "busyN at frame start", busyN, 0); break; end
    end
    for (int i = 0; i < 30; i++) step(($urandom & 1) != 0, 1, 0, 0);
    chk(busyN === 1'b1, "R5", "busyN after release", busyN, 1);
    // R4: forced abort in the middle of upstream traffic
    loadFrame(4);
    step(0, 1, 1, 1);
    for (int i = 0; i < 35; i++) step(($urandom & 1) != 0, 1, 0, 0);
    // R6: back-to-back request inside the release window
    loadFrame(3);
    step(1, 1, 1, 0);
    busyRises = 0;
    for (int i = 0; i < 25; i++) begin
      if (mSt == 3 && mWin == 3) begin loadFrame(2); step(1, 1, 1, 0); end
      else step(1, 1, 0, 0);
    end
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0);
    chk(busyRises == 0, "R6", "busy rises in back-to-back", busyRises, 0);
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0);
    // R8: sparse bit enables, two on, six off, upstream noise between
    loadFrame(5);
    for (int i = 0; i < 400; i++)
      step(((i % 8) < 2) ? 1'b1 : (($urandom & 1) != 0), (i % 8) < 2, i == 5, 0);
    loadFrame(3);
    for (int i = 0; i < 300; i++)
      step(($urandom % 4) != 0, (i % 8) < 2, i == 9, 1);
    chk(qBit.size() == 0, "R10", "source queue drained", qBit.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule